// File: doc/BRIEF.md
# Prioritized Level-Sensitive Interrupt Controller

This block collects 32 level-sensitive interrupt lines from peripherals and turns them into two processor request lines, a normal request and a fast request, plus a wake signal for leaving an idle state. Software reaches it through a word-wide register port. Through that port it enables or disables each line, sends each line to one of the two request outputs, and reads back masked and unmasked pending vectors.

A programmable table of priority slots sets the service order. Each slot holds a valid flag and the number of the source it names. The controller searches the table from slot 0 upward. It reports the first valid slot whose source is pending, enabled and routed to the normal request, through a highest-pending word that software polls. Software services a source by clearing its enable bit. The pending state follows the peripheral's line and clears only when the peripheral drops that line.

The read port is combinational: `bus_rdata` reflects `bus_addr` and the current state in the same cycle. Writes take effect at the clock edge on which `bus_wr` is high. Register offsets are byte addresses. An address whose low two bits are non-zero is not mapped.

Top module: `prio_intc`

## Requirements
- R1: After reset, the enable register, the routing register and the control register read 0. Every priority slot reads 0, with its valid flag clear. The highest-pending word reads 0, and `irq_o`, `fiq_o` and `wake_o` are 0.
- R2: The enable register at offset 0x004 is readable and writable. A source reaches any output or masked pending vector only while its enable bit is 1.
- R3: The routing register at offset 0x008 is readable and writable. A routing bit of 0 sends its source to the normal request, and a 1 sends it to the fast request.
- R4: Offset 0x000 reads `src_i & enable & ~routing`. Offset 0x00c reads `src_i & enable & routing`. Offset 0x010 reads `src_i` unmasked.
- R5: `irq_o` equals the OR of the 0x000 vector, and `fiq_o` equals the OR of the 0x00c vector, both taken one clock after the inputs.
- R6: Priority slot k sits at offset 0x01c + 4*k. Bit 31 is its valid flag and bits 14:0 are the source number. Both fields read back as written, and all other bits read 0.
- R7: The highest-pending word at 0x018 is found by scanning slots from index 0 upward. The scan picks the first slot that is valid, names a source below 32, and whose source is pending, enabled and routed to the normal request. For that slot the word reads bit 31 = 1 with the source number in bits 30:16. When no slot qualifies, the word reads 0.
- R8: Bit 0 of the control register at 0x014 is readable and writable, and its other bits read 0. One clock after the inputs, `wake_o` is the OR of `src_i & enable` when that bit is 1, and the OR of `src_i` when it is 0.
- R9: Writes to offsets 0x000, 0x00c, 0x010 and 0x018, to offsets outside the map and to misaligned addresses change nothing. Reads of unmapped or misaligned addresses return 0.
- R10: Pending is level-sensitive. Clearing a source's enable bit removes it from the outputs while 0x010 still shows the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level interrupt lines from peripherals |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |
| wake_o | output | 1 | Idle-wake indication, registered |

## Verification
Register reads and the highest-pending word are combinational. The bench therefore samples them one time step after setting the address, with no clock edge in between. A register write is visible in the first read after the edge that carried the strobe. `irq_o`, `fiq_o` and `wake_o` lag by one register, so the bench drives the lines and registers, waits for one more rising edge, and only then compares those outputs. Every drive and sample happens on the falling edge, away from the edge that updates state.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned SRC_FIELD_W = 15;
    localparam int unsigned TOP_SRC_LSB = 16;

    // word indices (byte offset / 4) of the register map
    localparam int unsigned IDX_IRQ_PEND = 0;
    localparam int unsigned IDX_ENABLE   = 1;
    localparam int unsigned IDX_ROUTE    = 2;
    localparam int unsigned IDX_FIQ_PEND = 3;
    localparam int unsigned IDX_RAW      = 4;
    localparam int unsigned IDX_CTRL     = 5;
    localparam int unsigned IDX_TOP      = 6;
    localparam int unsigned IDX_SLOT0    = 7;

    typedef struct packed {
        logic                   valid;
        logic [SRC_FIELD_W-1:0] src;
    } slot_t;

    function automatic logic [WORD_W-1:0] slot_to_word(slot_t s);
        return {s.valid, {(WORD_W-1-SRC_FIELD_W){1'b0}}, s.src};
    endfunction
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned WIDX_W    = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WIDX_W-1:0]           word_idx,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_SRC-1:0]          enable_q,
    output logic [NUM_SRC-1:0]          route_q,
    output logic                        wake_sel_q,
    output slot_t [NUM_SLOTS-1:0]       slots_q
);
    logic hit_enable, hit_route, hit_ctrl;

    assign hit_enable = wr_en && (word_idx == WIDX_W'(IDX_ENABLE));
    assign hit_route  = wr_en && (word_idx == WIDX_W'(IDX_ROUTE));
    assign hit_ctrl   = wr_en && (word_idx == WIDX_W'(IDX_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q   <= '0;
            route_q    <= '0;
            wake_sel_q <= 1'b0;
        end else begin
            if (hit_enable) enable_q   <= wdata[NUM_SRC-1:0];
            if (hit_route)  route_q    <= wdata[NUM_SRC-1:0];
            if (hit_ctrl)   wake_sel_q <= wdata[0];
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_t slot_r;
        logic  hit_slot;
        assign hit_slot = wr_en && (word_idx == WIDX_W'(IDX_SLOT0 + g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_r <= '0;
            end else if (hit_slot) begin
                slot_r.valid <= wdata[WORD_W-1];
                slot_r.src   <= wdata[SRC_FIELD_W-1:0];
            end
        end
        assign slots_q[g] = slot_r;
    end
endmodule

// File: rtl/pic_prio_scan.sv
module pic_prio_scan
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_SLOTS = 32
) (
    input  slot_t [NUM_SLOTS-1:0]  slots,
    input  logic  [NUM_SRC-1:0]    qual,
    output logic                   hit,
    output logic [SRC_FIELD_W-1:0] hit_src
);
    localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // walk from the lowest priority slot upward so that slot 0 overrides last
    always_comb begin
        hit     = 1'b0;
        hit_src = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slots[i].valid &&
                (slots[i].src < SRC_FIELD_W'(NUM_SRC)) &&
                qual[slots[i].src[SEL_W-1:0]]) begin
                hit     = 1'b1;
                hit_src = slots[i].src;
            end
        end
    end
endmodule

// File: rtl/pic_req_out.sv
module pic_req_out #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] enable,
    input  logic [NUM_SRC-1:0] route,
    input  logic               wake_sel,
    output logic [NUM_SRC-1:0] irq_vec,
    output logic [NUM_SRC-1:0] fiq_vec,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);
    logic wake_d;

    assign irq_vec = raw & enable & ~route;
    assign fiq_vec = raw & enable & route;
    assign wake_d  = wake_sel ? |(raw & enable) : |raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            fiq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |irq_vec;
            fiq_o  <= |fiq_vec;
            wake_o <= wake_d;
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic                   aligned;
    logic [WIDX_W-1:0]      word_idx;
    logic [NUM_SRC-1:0]     enable_q, route_q, irq_vec, fiq_vec;
    logic                   wake_sel_q;
    slot_t [NUM_SLOTS-1:0]  slots_q;
    logic                   top_hit;
    logic [SRC_FIELD_W-1:0] top_src;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[ADDR_W-1:2];

    pic_regfile #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .WIDX_W(WIDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr && aligned),
        .word_idx   (word_idx),
        .wdata      (bus_wdata),
        .enable_q   (enable_q),
        .route_q    (route_q),
        .wake_sel_q (wake_sel_q),
        .slots_q    (slots_q)
    );

    pic_req_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (src_i),
        .enable   (enable_q),
        .route    (route_q),
        .wake_sel (wake_sel_q),
        .irq_vec  (irq_vec),
        .fiq_vec  (fiq_vec),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o),
        .wake_o   (wake_o)
    );

    pic_prio_scan #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_scan (
        .slots   (slots_q),
        .qual    (irq_vec),
        .hit     (top_hit),
        .hit_src (top_src)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (word_idx)
                WIDX_W'(IDX_IRQ_PEND): bus_rdata = WORD_W'(irq_vec);
                WIDX_W'(IDX_ENABLE):   bus_rdata = WORD_W'(enable_q);
                WIDX_W'(IDX_ROUTE):    bus_rdata = WORD_W'(route_q);
                WIDX_W'(IDX_FIQ_PEND): bus_rdata = WORD_W'(fiq_vec);
                WIDX_W'(IDX_RAW):      bus_rdata = WORD_W'(src_i);
                WIDX_W'(IDX_CTRL):     bus_rdata = WORD_W'(wake_sel_q);
                WIDX_W'(IDX_TOP):      bus_rdata = {top_hit, top_src, {TOP_SRC_LSB{1'b0}}};
                default: begin
                    for (int k = 0; k < NUM_SLOTS; k++) begin
                        if (word_idx == WIDX_W'(IDX_SLOT0 + k))
                            bus_rdata = slot_to_word(slots_q[k]);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [NUM_SRC-1:0] route_q,
    input logic               wake_sel_q,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               wake_o
);
    localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // R5
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(src_i & enable_q & ~route_q)));

    // R5
    fiq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == $past(|(src_i & enable_q & route_q)));

    // R8
    wake_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o == $past(wake_sel_q ? |(src_i & enable_q) : |src_i));

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=> enable_q == $past(bus_wdata[NUM_SRC-1:0]));

    // R7
    top_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(24) && bus_rdata[31]) |->
            (src_i[bus_rdata[16 +: SEL_W]] && enable_q[bus_rdata[16 +: SEL_W]] &&
             !route_q[bus_rdata[16 +: SEL_W]]));

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(24))) |=>
            ($stable(enable_q) && $stable(route_q)));
endmodule

bind prio_intc pic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .enable_q   (enable_q),
    .route_q    (route_q),
    .wake_sel_q (wake_sel_q),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .wake_o     (wake_o)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o, wake_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_en, m_rt;
    logic        m_ctl;
    logic        tv [32];
    logic [14:0] ts [32];
    logic [31:0] rv;
    logic [31:0] seed;

    always #2 clk = ~clk;

    prio_intc dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] exp_top();
        for (int i = 0; i < 32; i++) begin
            if (tv[i] && ts[i] < 15'd32 &&
                src_i[ts[i][4:0]] && m_en[ts[i][4:0]] && !m_rt[ts[i][4:0]])
                return {1'b1, ts[i], 16'h0000};
        end
        return 32'h0;
    endfunction

    task automatic set_all(input logic [31:0] en, input logic [31:0] rt, input logic [31:0] s);
        wr(12'h004, en); m_en = en;
        wr(12'h008, rt); m_rt = rt;
        src_i = s;
        tick();
    endtask

    task automatic check_vectors(input string tag);
        rd(12'h000, rv); chk({tag, " R4 irq vec"}, rv, src_i & m_en & ~m_rt);
        rd(12'h00c, rv); chk({tag, " R4 fiq vec"}, rv, src_i & m_en & m_rt);
        rd(12'h010, rv); chk({tag, " R4 raw"}, rv, src_i);
        chk({tag, " R5 irq_o"}, 32'(irq_o), 32'(|(src_i & m_en & ~m_rt)));
        chk({tag, " R5 fiq_o"}, 32'(fiq_o), 32'(|(src_i & m_en & m_rt)));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_en = '0; m_rt = '0; m_ctl = 1'b0;
        for (int i = 0; i < 32; i++) begin tv[i] = 1'b0; ts[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(12'h004, rv); chk("R1 enable", rv, 0);
        rd(12'h008, rv); chk("R1 route", rv, 0);
        rd(12'h014, rv); chk("R1 ctrl", rv, 0);
        rd(12'h018, rv); chk("R1 top", rv, 0);
        rd(12'h01c, rv); chk("R1 slot0", rv, 0);
        rd(12'h098, rv); chk("R1 slot31", rv, 0);
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 fiq_o", 32'(fiq_o), 0);
        chk("R1 wake_o", 32'(wake_o), 0);

        // R2 / R3 readback
        wr(12'h004, 32'hA5A5_5A5A); rd(12'h004, rv); chk("R2 enable rw", rv, 32'hA5A5_5A5A);
        wr(12'h008, 32'h0F0F_F0F0); rd(12'h008, rv); chk("R3 route rw", rv, 32'h0F0F_F0F0);

        // R2 R3 R4 R5 R10 single-source sweep
        for (int s = 0; s < 32; s++) begin
            set_all(32'hFFFF_FFFF, (s % 2 == 1) ? (32'h1 << s) : 32'h0, 32'h1 << s);
            check_vectors("sweep");
            wr(12'h004, ~(32'h1 << s)); m_en = ~(32'h1 << s);
            tick();
            chk("R10 irq_o off", 32'(irq_o), 0);
            chk("R10 fiq_o off", 32'(fiq_o), 0);
            rd(12'h010, rv); chk("R10 raw held", rv, 32'h1 << s);
        end

        // R2 R3 R4 R5 R8 mixed patterns
        seed = 32'h1234_5678;
        for (int n = 0; n < 40; n++) begin
            logic [31:0] a, b, c;
            seed = nxt(seed); a = seed;
            seed = nxt(seed); b = seed;
            seed = nxt(seed); c = seed;
            if (n % 5 == 0) a = '0;
            m_ctl = n[0];
            wr(12'h014, 32'(m_ctl));
            set_all(b & ((n % 7 == 0) ? ~a : 32'hFFFF_FFFF), c, a);
            check_vectors("pattern");
            chk("R8 wake_o", 32'(wake_o), 32'(m_ctl ? |(src_i & m_en) : |src_i));
        end

        // R8 corner: raw pending but nothing enabled
        wr(12'h014, 32'hFFFF_FFFF); rd(12'h014, rv); chk("R8 ctrl rw", rv, 1);
        set_all(32'h0, 32'h0, 32'h0000_0100);
        chk("R8 wake gated", 32'(wake_o), 0);
        wr(12'h014, 32'h0); tick();
        chk("R8 wake raw", 32'(wake_o), 1);

        // R6 slot table programming and readback
        for (int i = 0; i < 32; i++) begin
            tv[i] = (i % 5 != 4);
            ts[i] = 15'((i * 7 + 3) % 40);
            wr(12'(12'h01c + 4 * i), {tv[i], 16'hFFFF, ts[i]} & 32'h8000_7FFF | 32'h0000_0000);
        end
        for (int i = 0; i < 32; i++) begin
            rd(12'(12'h01c + 4 * i), rv);
            chk("R6 slot rb", rv, {tv[i], 16'h0000, ts[i]});
        end

        // R7 priority search
        for (int n = 0; n < 60; n++) begin
            logic [31:0] a, b, c;
            seed = nxt(seed); a = seed;
            seed = nxt(seed); b = seed;
            seed = nxt(seed); c = seed & 32'h1111_1111;
            set_all(b | 32'hF000_0000, c, a);
            rd(12'h018, rv); chk("R7 top", rv, exp_top());
        end
        set_all(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
        rd(12'h018, rv); chk("R7 top all", rv, exp_top());
        wr(12'h01c, 32'h8000_0026); tv[0] = 1'b1; ts[0] = 15'd38;
        rd(12'h018, rv); chk("R7 skip src>=32", rv, exp_top());
        for (int i = 0; i < 32; i++) begin
            wr(12'(12'h01c + 4 * i), 32'h0000_0005); tv[i] = 1'b0; ts[i] = 15'd5;
        end
        rd(12'h018, rv); chk("R7 none valid", rv, 0);
        wr(12'h098, 32'h8000_0009); tv[31] = 1'b1; ts[31] = 15'd9;
        rd(12'h018, rv); chk("R7 last slot", rv, 32'h8009_0000);

        // R9 ignored writes and unmapped reads
        set_all(32'h00FF_00FF, 32'h0F00_0F00, 32'h0000_0000);
        wr(12'h000, 32'hFFFF_FFFF); wr(12'h00c, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF); wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF); wr(12'h005, 32'hFFFF_FFFF);
        rd(12'h004, rv); chk("R9 enable kept", rv, 32'h00FF_00FF);
        rd(12'h008, rv); chk("R9 route kept", rv, 32'h0F00_0F00);
        rd(12'h018, rv); chk("R9 top kept", rv, 0);
        rd(12'h000, rv); chk("R9 irq vec kept", rv, 0);
        rd(12'h09c, rv); chk("R9 past slots", rv, 0);
        rd(12'h200, rv); chk("R9 unmapped", rv, 0);
        rd(12'h005, rv); chk("R9 misaligned", rv, 0);
        chk("R9 irq_o kept", 32'(irq_o), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule